// File: doc/BRIEF.md
# Link Status LED Indicator Controller

This block turns a set of link and board status signals into eight LED drive levels that a person can read. A transmit or receive activity pulse, a link error or a configuration request may last a single clock cycle. The block stretches each of these pulses into a flash long enough to see. Level conditions such as low-power state or an unconfigured endpoint pass straight through to their LEDs.

Two LEDs carry more than one meaning. LED0 normally shows a 1 Hz heartbeat. During board bring-up it is overridden by two patterns: a steady-on level when the reference clock is unlocked, and a short flash every half second when the transceiver front end is still held in reset. LED3 normally flashes on link errors. It is overridden by a steady-on level while the link is polling or down, and that level is itself overridden by a 12 Hz blink when programming the clock generator has failed.

All pattern lengths come from one parameter, the clock frequency in Hz. A simulation can therefore scale the timing down. Every LED is registered, so each LED settles one clock after its inputs change.

Top module: `led_status_ctrl`

## Requirements
- R1: With the reference clock locked and no front-end reset pending, led[0] is a square wave with a period of CLK_HZ cycles. It is high for exactly CLK_HZ/2 cycles of each period.
- R2: While refclk_locked is low, led[0] is high on every cycle, one cycle after the input, whatever the state of fe_rst_pending.
- R3: With refclk_locked high and fe_rst_pending high, led[0] is high for CLK_HZ/20 cycles once in every CLK_HZ/2 cycles.
- R4: While i2c_cfg_fail is high, led[3] is a square wave with a period of CLK_HZ/12 cycles and a duty of one half. This takes precedence over link_down and over errors.
- R5: While link_down is high and i2c_cfg_fail is low, led[3] is steady on, even when error pulses arrive. On an established link with no errors, led[3] is off.
- R6: An err_up_pulse lights led[4], and an err_dn_pulse lights led[5]. Each lights its LED for exactly CLK_HZ/20 cycles, starting two cycles after the pulse. When i2c_cfg_fail is low, led[3] is on whenever led[4] or led[5] is on.
- R7: A pulse that arrives while its flash is still lit restarts the flash. The LED then stays on for CLK_HZ/20 cycles counted from the latest pulse.
- R8: A tx_act_pulse lights led[1], and an rx_act_pulse lights led[2]. Each flash has the same length and timing as in R6.
- R9: led[6] is on one cycle after ep_unconfigured is high. It is also on for a stretched flash, timed as in R6, after each cfg_req_pulse.
- R10: led[7] follows low_power with one cycle of delay.
- R11: All eight LEDs are off while rst_n is low. They stay off for the two clock edges after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| refclk_locked | input | 1 | External reference clock reports lock |
| fe_rst_pending | input | 1 | Transceiver front end still held in reset |
| i2c_cfg_fail | input | 1 | Clock generator programming over I2C failed |
| link_down | input | 1 | Link is polling or down |
| err_up_pulse | input | 1 | One-cycle error event on the link toward the host |
| err_dn_pulse | input | 1 | One-cycle error event on the link from the host |
| tx_act_pulse | input | 1 | One-cycle data activity toward the host |
| rx_act_pulse | input | 1 | One-cycle data activity from the host |
| ep_unconfigured | input | 1 | Device is not configured (level) |
| cfg_req_pulse | input | 1 | One-cycle set-configuration or set-interface request |
| low_power | input | 1 | Link is in U1, U2 or U3 |
| led | output | 8 | LED drive levels, 1 is lit |

## Verification
The hardest situation to reach is a retrigger: a second pulse landing while a flash is already lit. From the ports, a block that restarts its timer looks the same as one that ignores the second pulse, until the first flash would have ended. The stimulus fires a second pulse halfway through a flash. It then counts the lit cycles that follow, which separates a restart from a missed pulse. The overlapping bring-up faults also need care. I2C failure, link down and error pulses are applied together, and then released one at a time. Each blink pattern is measured by counting lit cycles and rising edges over exactly one whole pattern window, so the result does not depend on the phase of the pattern.

// File: rtl/ledind_pkg.sv
package ledind_pkg;
  localparam int NUM_EV     = 5;
  localparam int EV_TX      = 0;
  localparam int EV_RX      = 1;
  localparam int EV_ERR_UP  = 2;
  localparam int EV_ERR_DN  = 3;
  localparam int EV_CFG_REQ = 4;

  // cycles in 1/div of a second, never below two
  function automatic int unsigned cycles_div(input int unsigned clk_hz,
                                             input int unsigned div);
    int unsigned q;
    q = clk_hz / div;
    return (q < 2) ? 2 : q;
  endfunction
endpackage

// File: rtl/ledind_rst_sync.sv
module ledind_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/ledind_blinker.sv
module ledind_blinker #(
  parameter int unsigned PERIOD    = 100,
  parameter int unsigned ON_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic wave
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] ON_L = CNT_W'(ON_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wave = (cnt_q < ON_L);
endmodule

// File: rtl/ledind_stretch.sv
module ledind_stretch #(
  parameter int unsigned LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic lit
);
  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LEN_L = CNT_W'(LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trig)               cnt_d = LEN_L;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lit = (cnt_q != '0);
endmodule

// File: rtl/ledind_select.sv
module ledind_select
  import ledind_pkg::*;
(
  input  logic              hb_wave,
  input  logic              fe_wave,
  input  logic              fast_wave,
  input  logic              refclk_locked,
  input  logic              fe_rst_pending,
  input  logic              i2c_cfg_fail,
  input  logic              link_down,
  input  logic [NUM_EV-1:0] ev_lit,
  input  logic              ep_unconfigured,
  input  logic              low_power,
  output logic [7:0]        led_d
);
  logic any_err;

  always_comb begin
    any_err = ev_lit[EV_ERR_UP] | ev_lit[EV_ERR_DN];

    // LED0: unlocked clock beats pending front end beats heartbeat
    if (!refclk_locked)       led_d[0] = 1'b1;
    else if (fe_rst_pending)  led_d[0] = fe_wave;
    else                      led_d[0] = hb_wave;

    led_d[1] = ev_lit[EV_TX];
    led_d[2] = ev_lit[EV_RX];

    // LED3: I2C failure beats link down beats error flash
    if (i2c_cfg_fail)         led_d[3] = fast_wave;
    else if (link_down)       led_d[3] = 1'b1;
    else                      led_d[3] = any_err;

    led_d[4] = ev_lit[EV_ERR_UP];
    led_d[5] = ev_lit[EV_ERR_DN];
    led_d[6] = ep_unconfigured | ev_lit[EV_CFG_REQ];
    led_d[7] = low_power;
  end
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
  import ledind_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refclk_locked,
  input  logic       fe_rst_pending,
  input  logic       i2c_cfg_fail,
  input  logic       link_down,
  input  logic       err_up_pulse,
  input  logic       err_dn_pulse,
  input  logic       tx_act_pulse,
  input  logic       rx_act_pulse,
  input  logic       ep_unconfigured,
  input  logic       cfg_req_pulse,
  input  logic       low_power,
  output logic [7:0] led
);
  localparam int unsigned HB_PERIOD   = cycles_div(CLK_HZ, 1);
  localparam int unsigned HB_ON       = cycles_div(CLK_HZ, 2);
  localparam int unsigned FE_PERIOD   = cycles_div(CLK_HZ, 2);
  localparam int unsigned FE_ON       = cycles_div(CLK_HZ, 20);
  localparam int unsigned FAST_PERIOD = cycles_div(CLK_HZ, 12);
  localparam int unsigned FAST_ON     = cycles_div(CLK_HZ, 24);
  localparam int unsigned STRETCH_LEN = cycles_div(CLK_HZ, 20);

  logic              rst_q_n;
  logic              hb_wave, fe_wave, fast_wave;
  logic [NUM_EV-1:0] ev_pulse, ev_lit;
  logic [7:0]        led_d;

  ledind_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ledind_blinker #(.PERIOD(HB_PERIOD), .ON_CYCLES(HB_ON)) i_hb (
    .clk(clk), .rst_n(rst_q_n), .en(1'b1), .wave(hb_wave)
  );

  ledind_blinker #(.PERIOD(FE_PERIOD), .ON_CYCLES(FE_ON)) i_fe (
    .clk(clk), .rst_n(rst_q_n), .en(1'b1), .wave(fe_wave)
  );

  ledind_blinker #(.PERIOD(FAST_PERIOD), .ON_CYCLES(FAST_ON)) i_fast (
    .clk(clk), .rst_n(rst_q_n), .en(1'b1), .wave(fast_wave)
  );

  always_comb begin
    ev_pulse             = '0;
    ev_pulse[EV_TX]      = tx_act_pulse;
    ev_pulse[EV_RX]      = rx_act_pulse;
    ev_pulse[EV_ERR_UP]  = err_up_pulse;
    ev_pulse[EV_ERR_DN]  = err_dn_pulse;
    ev_pulse[EV_CFG_REQ] = cfg_req_pulse;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_stretch
    ledind_stretch #(.LEN(STRETCH_LEN)) i_stretch (
      .clk   (clk),
      .rst_n (rst_q_n),
      .trig  (ev_pulse[g]),
      .lit   (ev_lit[g])
    );
  end

  ledind_select i_select (
    .hb_wave         (hb_wave),
    .fe_wave         (fe_wave),
    .fast_wave       (fast_wave),
    .refclk_locked   (refclk_locked),
    .fe_rst_pending  (fe_rst_pending),
    .i2c_cfg_fail    (i2c_cfg_fail),
    .link_down       (link_down),
    .ev_lit          (ev_lit),
    .ep_unconfigured (ep_unconfigured),
    .low_power       (low_power),
    .led_d           (led_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) led <= '0;
    else          led <= led_d;
  end
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       refclk_locked,
  input logic       i2c_cfg_fail,
  input logic       link_down,
  input logic       err_up_pulse,
  input logic       err_dn_pulse,
  input logic       tx_act_pulse,
  input logic       ep_unconfigured,
  input logic       low_power,
  input logic [7:0] led
);
  assert_unlocked_on_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !refclk_locked |=> led[0]);

  assert_link_down_on_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (link_down && !i2c_cfg_fail) |=> led[3]);

  assert_err_shows_on_any_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !i2c_cfg_fail |=> (!(led[4] || led[5]) || led[3]));

  assert_up_flash_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_up_pulse |-> ##2 led[4]);

  assert_dn_flash_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_dn_pulse |-> ##2 led[5]);

  assert_tx_flash_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    tx_act_pulse |-> ##2 led[1]);

  assert_unconfigured_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    ep_unconfigured |=> led[6]);

  assert_low_power_on_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    low_power |=> led[7]);

  assert_low_power_off_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !low_power |=> !led[7]);

  assert_reset_dark_R11: assert property (@(posedge clk)
    !rst_q_n |-> (led == 8'h00));
endmodule

bind led_status_ctrl led_status_chk i_led_status_chk (
  .clk             (clk),
  .rst_q_n         (rst_q_n),
  .refclk_locked   (refclk_locked),
  .i2c_cfg_fail    (i2c_cfg_fail),
  .link_down       (link_down),
  .err_up_pulse    (err_up_pulse),
  .err_dn_pulse    (err_dn_pulse),
  .tx_act_pulse    (tx_act_pulse),
  .ep_unconfigured (ep_unconfigured),
  .low_power       (low_power),
  .led             (led)
);

// File: tb/test_led_status_ctrl.sv
module test_led_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned HZ = 2400;
  localparam int HB_P   = HZ;
  localparam int FE_P   = HZ / 2;
  localparam int FE_ON  = HZ / 20;
  localparam int FAST_P = HZ / 12;
  localparam int LEN    = HZ / 20;

  logic clk = 1'b0;
  logic rst_n;
  logic refclk_locked, fe_rst_pending, i2c_cfg_fail, link_down;
  logic err_up_pulse, err_dn_pulse, tx_act_pulse, rx_act_pulse;
  logic ep_unconfigured, cfg_req_pulse, low_power;
  logic [7:0] led;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  led_status_ctrl #(.CLK_HZ(HZ)) i_led_status_ctrl (
    .clk(clk), .rst_n(rst_n),
    .refclk_locked(refclk_locked), .fe_rst_pending(fe_rst_pending),
    .i2c_cfg_fail(i2c_cfg_fail), .link_down(link_down),
    .err_up_pulse(err_up_pulse), .err_dn_pulse(err_dn_pulse),
    .tx_act_pulse(tx_act_pulse), .rx_act_pulse(rx_act_pulse),
    .ep_unconfigured(ep_unconfigured), .cfg_req_pulse(cfg_req_pulse),
    .low_power(low_power), .led(led)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // samples led[idx] on n successive falling edges
  task automatic measure(input int idx, input int n, output int ones, output int rises);
    logic prev;
    prev = led[idx];
    ones = 0;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (led[idx]) ones++;
      if (led[idx] && !prev) rises++;
      prev = led[idx];
    end
  endtask

  // drive a one-cycle pulse; returns on the first sample after the capturing edge
  task automatic fire(input int which);
    @(negedge clk);
    case (which)
      0: tx_act_pulse  = 1'b1;
      1: rx_act_pulse  = 1'b1;
      2: err_up_pulse  = 1'b1;
      3: err_dn_pulse  = 1'b1;
      default: cfg_req_pulse = 1'b1;
    endcase
    @(negedge clk);
    tx_act_pulse = 1'b0; rx_act_pulse = 1'b0; err_up_pulse = 1'b0;
    err_dn_pulse = 1'b0; cfg_req_pulse = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 dark in reset", led, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 dark edge 1", led, 0);
    @(negedge clk);
    check("R11 dark edge 2", led, 0);
    settle();
  endtask

  task automatic t_heartbeat();
    int o, r;
    measure(0, HB_P, o, r);
    check("R1 heartbeat on cycles", o, HB_P / 2);
    check("R1 heartbeat rises", r, 1);
  endtask

  task automatic t_led0_faults();
    int o, r;
    refclk_locked = 1'b0; fe_rst_pending = 1'b1;
    settle();
    measure(0, HB_P, o, r);
    check("R2 unlocked steady", o, HB_P);
    refclk_locked = 1'b1;
    settle();
    measure(0, FE_P, o, r);
    check("R3 front-end flash on cycles", o, FE_ON);
    check("R3 front-end flash count", r, 1);
    fe_rst_pending = 1'b0;
    settle();
    t_heartbeat();
  endtask

  task automatic t_led3_prio();
    int o, r;
    check("R5 healthy link led3 off", int'(led[3]), 0);
    i2c_cfg_fail = 1'b1; link_down = 1'b1;
    settle();
    measure(3, HB_P / 2, o, r);
    check("R4 fast blink on cycles", o, HB_P / 4);
    check("R4 fast blink rises", r, (HB_P / 2) / FAST_P);
    i2c_cfg_fail = 1'b0;
    settle();
    fire(2);
    measure(3, 3 * LEN, o, r);
    check("R5 link down steady on", o, 3 * LEN);
    link_down = 1'b0;
    settle();
  endtask

  task automatic t_flash(input int which, input int idx, input string req);
    int o, r;
    fire(which);
    check({req, " not lit on first edge"}, int'(led[idx]), 0);
    measure(idx, LEN + 8, o, r);
    check({req, " flash length"}, o, LEN);
    check({req, " single flash"}, r, 1);
  endtask

  task automatic t_errors();
    int o, r;
    t_flash(2, 4, "R6 upstream");
    fire(3);
    measure(5, LEN + 8, o, r);
    check("R6 downstream flash length", o, LEN);
    fire(3);
    measure(3, LEN + 8, o, r);
    check("R6 led3 with downstream error", o, LEN);
    measure(4, 4, o, r);
    check("R6 led4 quiet on downstream error", o, 0);
  endtask

  task automatic t_retrigger();
    int o, r;
    fire(2);
    repeat (LEN / 2) @(negedge clk);
    fire(2);
    check("R7 still lit at retrigger", int'(led[4]), 1);
    measure(4, LEN + 8, o, r);
    check("R7 restarted flash remaining", o, LEN);
  endtask

  task automatic t_activity();
    t_flash(0, 1, "R8 tx");
    t_flash(1, 2, "R8 rx");
  endtask

  task automatic t_config();
    int o, r;
    ep_unconfigured = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 unconfigured lit", int'(led[6]), 1);
    ep_unconfigured = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 configured dark", int'(led[6]), 0);
    t_flash(4, 6, "R9 config request");
  endtask

  task automatic t_low_power();
    @(negedge clk);
    low_power = 1'b1;
    @(negedge clk);
    check("R10 low power lit", int'(led[7]), 1);
    low_power = 1'b0;
    @(negedge clk);
    check("R10 low power cleared", int'(led[7]), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    refclk_locked = 1'b1; fe_rst_pending = 1'b0; i2c_cfg_fail = 1'b0;
    link_down = 1'b0; err_up_pulse = 1'b0; err_dn_pulse = 1'b0;
    tx_act_pulse = 1'b0; rx_act_pulse = 1'b0; ep_unconfigured = 1'b0;
    cfg_req_pulse = 1'b0; low_power = 1'b0;
    t_reset();
    t_heartbeat();
    t_led0_faults();
    t_led3_prio();
    t_errors();
    t_retrigger();
    t_activity();
    t_config();
    t_low_power();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule